// File: doc/BRIEF.md
# Serial Configuration Frame Loader

This block loads configuration data into a small configuration memory. Data arrives either one bit per beat or one byte per beat, as the mode input selects. The bits collect in a staging register. The configuration memory never holds a partly built frame. Each time the staging register fills, its whole contents go to the memory in a single write, at a frame address that starts at zero and steps by one per frame.

When the last frame has been written, a completion flag rises. While loading is still under way, a hold output keeps the surrounding user logic disabled. A synchronous restart input returns the loader to frame zero so that the device can be configured again. The frame width, the frame count and the parallel width are parameters. A read port lets the contents of the memory be observed.

Top module: `cfg_frame_loader`

## Requirements
- R1: While reset is held and during the first cycles after it, `cfg_done` is 0, `user_hold` is 1, `wr_strobe` is 0 and `wr_addr` is 0.
- R2: With `mode` = 3'b000, each cycle with `data_valid` high takes one bit from `data_bit`. A frame is FRAME_W such beats, and the first bit received ends up in the most significant bit of the frame.
- R3: With `mode` = 3'b001, each valid cycle takes PAR_W bits from `data_byte`. A frame is FRAME_W/PAR_W beats, and the first byte received ends up in the most significant byte.
- R4: The memory is written only as a whole frame. `wr_strobe` is high for exactly one cycle per completed frame, in the cycle after the beat that completed the frame, and at no other time.
- R5: The first frame goes to address 0. Each later frame goes to the address one above the previous frame's address, and `wr_addr` shows the address of the pending write.
- R6: `cfg_done` rises on the clock edge that writes frame NUM_FRAMES-1. It stays high until reset or `init`.
- R7: `user_hold` is the inverse of `cfg_done` in every cycle.
- R8: The mode codes 3'b010 to 3'b111 are reserved. While one of them is applied, valid beats are ignored and do not advance the bit count.
- R9: Once `cfg_done` is high, valid beats are ignored. No write occurs and the memory contents stay unchanged.
- R10: A cycle with `init` high clears the frame address, the partial bit count and `cfg_done`. A following load starts again at address 0 with an empty staging register.
- R11: Cycles with `data_valid` low change nothing, whatever `data_bit` and `data_byte` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init | input | 1 | Synchronous restart of the load sequence |
| mode | input | 3 | 000 = one bit per beat, 001 = PAR_W bits per beat, other codes reserved |
| data_valid | input | 1 | A beat is offered in this cycle |
| data_bit | input | 1 | Serial data bit |
| data_byte | input | PAR_W | Parallel data word |
| rd_addr | input | $clog2(NUM_FRAMES) | Frame address to read back |
| rd_data | output | FRAME_W | Stored frame at `rd_addr` |
| wr_strobe | output | 1 | A whole frame is written to memory in this cycle |
| wr_addr | output | $clog2(NUM_FRAMES) | Address of the next or current frame write |
| cfg_done | output | 1 | All frames have been written |
| user_hold | output | 1 | Keeps user logic disabled while loading is under way |

## Verification
The assertions assume that `mode` stays constant while a frame is being gathered. They also assume that `init` never coincides with reset release in a way that matters, so a frame is always built entirely in one beat width. The stimulus changes `mode` only between frames, or right after an `init` pulse. It sweeps every reserved code while the staging register is empty. Gaps with random-looking data on the data pins are placed between beats, so that an ignored beat would show up as a misaligned frame in memory.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic [2:0] {
    MODE_SERIAL = 3'b000,
    MODE_BYTE   = 3'b001
  } load_mode_e;

  function automatic logic mode_active(input logic [2:0] m);
    return (m == MODE_SERIAL) || (m == MODE_BYTE);
  endfunction
endpackage

// File: rtl/cfl_frame_shift.sv
module cfl_frame_shift #(
  parameter int FRAME_W = 32,
  parameter int PAR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               beat,
  input  logic               wide,
  input  logic               bit_in,
  input  logic [PAR_W-1:0]   byte_in,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_full
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               full_q, full_d;
  logic [CNT_W:0]     cnt_sum;
  logic [CNT_W-1:0]   step;

  always_comb begin
    step    = wide ? CNT_W'(PAR_W) : CNT_W'(1);
    cnt_sum = {1'b0, cnt_q} + {1'b0, step};
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    full_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (beat) begin
      if (wide) shreg_d = (shreg_q << PAR_W) | FRAME_W'(byte_in);
      else      shreg_d = {shreg_q[FRAME_W-2:0], bit_in};
      if (cnt_sum >= (CNT_W+1)'(FRAME_W)) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
    end
  end

  assign frame      = shreg_q;
  assign frame_full = full_q;
endmodule

// File: rtl/cfl_frame_seq.sv
module cfl_frame_seq #(
  parameter int NUM_FRAMES = 16,
  parameter int AW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          frame_full,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(NUM_FRAMES - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (clr) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (frame_full && !done_q) begin
      if (addr_q == LAST) done_d = 1'b1;
      else                addr_d = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;
endmodule

// File: rtl/cfl_frame_mem.sv
module cfl_frame_mem #(
  parameter int FRAME_W    = 32,
  parameter int NUM_FRAMES = 16,
  parameter int AW         = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [FRAME_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [FRAME_W-1:0] rdata
);
  logic [FRAME_W-1:0] cells [NUM_FRAMES];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader #(
  parameter int FRAME_W    = 32,
  parameter int NUM_FRAMES = 16,
  parameter int PAR_W      = 8,
  parameter int AW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic [2:0]         mode,
  input  logic               data_valid,
  input  logic               data_bit,
  input  logic [PAR_W-1:0]   data_byte,
  input  logic [AW-1:0]      rd_addr,
  output logic [FRAME_W-1:0] rd_data,
  output logic               wr_strobe,
  output logic [AW-1:0]      wr_addr,
  output logic               cfg_done,
  output logic               user_hold
);
  import cfl_pkg::*;

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic               beat, wide, full, done;
  logic [FRAME_W-1:0] frame;
  logic [AW-1:0]      addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wide = (mode == MODE_BYTE);
  assign beat = data_valid && mode_active(mode) && !done && !init;

  cfl_frame_shift #(.FRAME_W(FRAME_W), .PAR_W(PAR_W)) shift_i (
    .clk(clk), .rst_n(core_rst_n), .clr(init), .beat(beat), .wide(wide),
    .bit_in(data_bit), .byte_in(data_byte), .frame(frame), .frame_full(full)
  );

  cfl_frame_seq #(.NUM_FRAMES(NUM_FRAMES), .AW(AW)) seq_i (
    .clk(clk), .rst_n(core_rst_n), .clr(init), .frame_full(full),
    .addr(addr), .done(done)
  );

  cfl_frame_mem #(.FRAME_W(FRAME_W), .NUM_FRAMES(NUM_FRAMES), .AW(AW)) mem_i (
    .clk(clk), .we(full && !done && !init), .waddr(addr), .wdata(frame),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign wr_strobe = full && !done && !init;
  assign wr_addr   = addr;
  assign cfg_done  = done;
  assign user_hold = !done;
endmodule

// File: rtl/cfg_frame_loader_chk.sv
module cfg_frame_loader_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic          data_valid,
  input logic          wr_strobe,
  input logic [AW-1:0] wr_addr,
  input logic          cfg_done,
  input logic          user_hold
);
  AST_WRITE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(data_valid)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !init) |=> (cfg_done || (wr_addr == $past(wr_addr) + AW'(1)))); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !init) |=> cfg_done); // R6
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(user_hold) |-> $rose(cfg_done)); // R7
  AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !wr_strobe); // R9
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!cfg_done && wr_addr == '0)); // R10
endmodule

bind cfg_frame_loader cfg_frame_loader_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .init(init), .data_valid(data_valid),
  .wr_strobe(wr_strobe), .wr_addr(wr_addr), .cfg_done(cfg_done),
  .user_hold(user_hold)
);

// File: tb/cfg_frame_loader_tb.sv
module cfg_frame_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16;
  localparam int NF = 4;
  localparam int PW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          data_valid = 1'b0;
  logic          data_bit = 1'b0;
  logic [PW-1:0] data_byte = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [FW-1:0] rd_data;
  logic          wr_strobe;
  logic [AW-1:0] wr_addr;
  logic          cfg_done;
  logic          user_hold;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit finished = 1'b0;
  logic [FW-1:0] expect_mem [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_frame_loader #(.FRAME_W(FW), .NUM_FRAMES(NF), .PAR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .mode(mode),
    .data_valid(data_valid), .data_bit(data_bit), .data_byte(data_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .cfg_done(cfg_done), .user_hold(user_hold)
  );

  always @(negedge clk) if (wr_strobe === 1'b1) strobes++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic gap(input int n);
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      data_valid = 1'b0;
      data_bit   = ~data_bit;
      data_byte  = data_byte ^ 8'h5a;
    end
  endtask

  // Sends one frame MSB first, one bit per beat, with idle gaps of junk data (R2, R11)
  task automatic send_serial(input logic [FW-1:0] v);
    for (int i = FW - 1; i >= 0; i--) begin
      @(negedge clk);
      data_valid = 1'b1;
      data_bit   = v[i];
      if (i % 5 == 2) gap(1);
    end
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  // Sends one frame most significant byte first (R3)
  task automatic send_par(input logic [FW-1:0] v);
    for (int j = FW/PW - 1; j >= 0; j--) begin
      @(negedge clk);
      data_valid = 1'b1;
      data_byte  = v[j*PW +: PW];
      gap(2);
      if (j != 0) begin
        @(negedge clk);
        data_valid = 1'b0;
      end
    end
  endtask

  task automatic check_mem(input string req);
    for (int a = 0; a < NF; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      #1;
      check(req, 32'(rd_data), 32'(expect_mem[a]));
    end
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init = 1'b1;
    data_valid = 1'b1;
    @(negedge clk);
    init = 1'b0;
    data_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", 32'(cfg_done), 0);
    check("R1 hold", 32'(user_hold), 1);
    check("R1 strobe", 32'(wr_strobe), 0);
    check("R1 addr", 32'(wr_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {30'd0, cfg_done, user_hold}, 32'd1);

    // Serial load, first frame timed exactly (R2 R4 R5)
    mode = 3'b000;
    for (int f = 0; f < NF; f++) begin
      expect_mem[f] = FW'(16'ha5c3 ^ (f * 16'h1357) ^ (16'h8000 >> f));
      send_serial(expect_mem[f]);
      // the negedge after the last beat: write pending
      check("R4 strobe after frame", 32'(wr_strobe), 1);
      check("R5 addr", 32'(wr_addr), 32'(f));
      check("R6 done before final write", 32'(cfg_done), 0);
      check("R7 hold during load", 32'(user_hold), 1);
      @(negedge clk);
      check("R4 single strobe", 32'(wr_strobe), 0);
    end
    check("R6 done after last frame", 32'(cfg_done), 1);
    check("R7 hold released", 32'(user_hold), 0);
    check("R4 strobe count", 32'(strobes), 32'(NF));
    check_mem("R2 serial contents");

    // R9: beats after done ignored
    s0 = strobes;
    send_serial(16'h0f0f);
    gap(3);
    check("R9 no strobe after done", 32'(strobes), 32'(s0));
    check("R9 done held", 32'(cfg_done), 1);
    check_mem("R9 memory unchanged");

    // R10: init restarts
    pulse_init();
    check("R10 done cleared", 32'(cfg_done), 0);
    check("R10 hold reasserted", 32'(user_hold), 1);
    check("R10 addr cleared", 32'(wr_addr), 0);

    // R8: every reserved code, with valid beats, does nothing
    s0 = strobes;
    for (int m = 2; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m);
      for (int b = 0; b < FW; b++) begin
        @(negedge clk);
        data_valid = 1'b1;
        data_bit   = 1'(b);
        data_byte  = 8'(b * 37);
      end
      @(negedge clk);
      data_valid = 1'b0;
    end
    gap(2);
    check("R8 no strobe in reserved modes", 32'(strobes), 32'(s0));
    check("R8 addr unchanged", 32'(wr_addr), 0);

    // Parallel load; misalignment would show if reserved beats counted (R3 R8 R11)
    @(negedge clk);
    mode = 3'b001;
    for (int f = 0; f < NF; f++) begin
      expect_mem[f] = FW'((f + 1) * 16'h2b71) ^ FW'(16'h00ff << (2 * f));
      send_par(expect_mem[f]);
      gap(2);
    end
    check("R6 done after parallel load", 32'(cfg_done), 1);
    check("R4 parallel strobe count", 32'(strobes - s0), 32'(NF));
    check_mem("R3 parallel contents");

    // R10: init mid-frame discards partial bits
    pulse_init();
    mode = 3'b000;
    for (int i = 0; i < FW/2; i++) begin
      @(negedge clk);
      data_valid = 1'b1;
      data_bit   = 1'b1;
    end
    @(negedge clk);
    data_valid = 1'b0;
    pulse_init();
    s0 = strobes;
    expect_mem[0] = 16'h1248;
    send_serial(expect_mem[0]);
    gap(2);
    check("R10 one frame after mid init", 32'(strobes - s0), 1);
    check("R10 addr advanced once", 32'(wr_addr), 1);
    @(negedge clk);
    rd_addr = '0;
    #1;
    check("R10 fresh frame stored", 32'(rd_data), 32'(expect_mem[0]));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule